// File: doc/BRIEF.md
# Per-Function Outbound Request Stop Gate

This block sits on the outbound request path between an internal requester and a PCIe core. It keeps one stop flag for each physical function. A flag is raised by hardware when its function enters function level reset. While the flag is up, every posted or non-posted request owned by that function is removed from the path and never reaches the core. The function number carried with a request names the owning physical function, which also covers requests from its child virtual functions.

A removed non-posted request is answered at once with an error completion that carries the original request tag back to the requester, so the requester never has to wait for a timeout. Every removal also sets a sticky per-function error status bit. The error interrupt is a level output that stays high while any status bit is set.

Software clears stop flags and status bits by writing ones through a small register port. The flags survive the soft reset, which only clears the status bits and any pending error completion. The MAC reset clears everything.

Top module: `fn_stop_gate`

## Requirements
- R1: Register address 0 reads the stop flags in bits [NUM_PF-1:0], and address 1 reads the error status bits in the same positions. All higher read bits are zero, and after MAC reset both registers read zero and `err_irq` is low.
- R2: A pulse on `flr_enter[i]` sets stop flag i at the next clock edge.
- R3: A request whose `req_pf` names a function with its stop flag set never shows on `core_valid`. It is accepted without regard to `core_ready`: a posted request always, and a non-posted one whenever the completion slot is free or draining.
- R4: A request from a function whose flag is clear passes through in the same cycle: `core_valid` follows `req_valid`, `req_ready` follows `core_ready`, and pf, type and tag are forwarded unchanged.
- R5: An accepted non-posted request that is dropped raises `cpl_valid` on the next cycle with the request's tag and pf. The completion holds until `cpl_ready`, and a further dropped non-posted request is stalled (`req_ready` low) while the slot is full and not draining.
- R6: Each dropped request, posted or non-posted, sets status bit `req_pf` on the next cycle, and `err_irq` is high while any status bit is set.
- R7: Writing address 0 clears each stop flag whose write-data bit is 1. Zero bits and bits above NUM_PF-1 have no effect, and an FLR set in the same cycle as a clear wins.
- R8: Writing address 1 clears each status bit whose write-data bit is 1. A drop in the same cycle as a clear of that bit wins, and `err_irq` falls once all bits are cleared.
- R9: Holding `soft_rst_n` low clears the status bits and any pending error completion, but leaves the stop flags as they were.
- R10: MAC reset (`mac_rst_n` low) clears the stop flags, the status bits and the completion slot.
- R11: A `req_pf` value of NUM_PF or above matches no flag and is always passed through to the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mac_rst_n | input | 1 | MAC reset, asynchronous, active low; clears all state |
| soft_rst_n | input | 1 | Soft reset, synchronous, active low; spares the stop flags |
| flr_enter | input | NUM_PF | Per-function pulse: function enters function level reset |
| req_valid | input | 1 | Outbound request valid |
| req_ready | output | 1 | Outbound request accepted |
| req_pf | input | PF_W | Owning physical function of the request |
| req_np | input | 1 | 1 = non-posted, 0 = posted |
| req_tag | input | TAG_W | Request tag |
| core_valid | output | 1 | Request valid toward the core |
| core_ready | input | 1 | Core accepts the request |
| core_pf | output | PF_W | Forwarded function number |
| core_np | output | 1 | Forwarded request type |
| core_tag | output | TAG_W | Forwarded tag |
| cpl_valid | output | 1 | Error completion valid toward the requester |
| cpl_ready | input | 1 | Requester accepts the error completion |
| cpl_pf | output | PF_W | Function of the dropped request |
| cpl_tag | output | TAG_W | Tag of the dropped request |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 1 | Register select: 0 stop flags, 1 error status |
| csr_wdata | input | CSR_W | Write data, one bit per function clears |
| csr_rdata | output | CSR_W | Read data of the selected register |
| err_irq | output | 1 | Level error interrupt |

## Verification
On every cycle the assertions check that an FLR pulse lands in its flag, that a stopped function never drives the core, that each drop leaves its status bit and the interrupt set, that a dropped non-posted request yields a completion with its tag, that a stalled completion holds, that the soft reset never clears a flag, and that the interrupt only falls after a status write or a soft reset. The set-over-clear priority for both registers, the no-effect writes of zeros and upper bits, the zero read of upper bits, and the full MAC reset are shown only by the bench's scenarios, since each hinges on a particular ordering of writes and events.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    // register select on csr_addr
    typedef enum logic {
        SEL_STOP = 1'b0,
        SEL_ERR  = 1'b1
    } fsg_sel_e;

endpackage

// File: rtl/fsg_w1c_bank.sv
// Bank of sticky bits: hardware sets, software clears by writing 1,
// set beats clear; optional synchronous wipe.
module fsg_w1c_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         mac_rst_n,
    input  logic         wipe_i,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);

    typedef struct packed {
        logic [N-1:0] bits;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits & ~clr_i) | set_i;
        if (wipe_i) begin
            st_d.bits = '0;
        end
    end

    always_ff @(posedge clk or negedge mac_rst_n) begin
        if (!mac_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.bits;

endmodule

// File: rtl/fsg_err_slot.sv
// One-entry holding register for the synthesized error completion.
module fsg_err_slot #(
    parameter int TAG_W = 8,
    parameter int PF_W  = 2
) (
    input  logic             clk,
    input  logic             mac_rst_n,
    input  logic             soft_rst_n,
    input  logic             load_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic [PF_W-1:0]  pf_i,
    output logic             free_o,
    output logic             valid_o,
    input  logic             ready_i,
    output logic [TAG_W-1:0] tag_o,
    output logic [PF_W-1:0]  pf_o
);

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PF_W-1:0]  pf;
    } slot_t;

    slot_t sl_d, sl_q;

    assign free_o = !sl_q.valid || ready_i;

    always_comb begin
        sl_d = sl_q;
        if (sl_q.valid && ready_i) begin
            sl_d.valid = 1'b0;
        end
        if (load_i) begin
            sl_d.valid = 1'b1;
            sl_d.tag   = tag_i;
            sl_d.pf    = pf_i;
        end
        if (!soft_rst_n) begin
            sl_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge mac_rst_n) begin
        if (!mac_rst_n) begin
            sl_q <= '0;
        end else begin
            sl_q <= sl_d;
        end
    end

    assign valid_o = sl_q.valid;
    assign tag_o   = sl_q.tag;
    assign pf_o    = sl_q.pf;

endmodule

// File: rtl/fn_stop_gate.sv
module fn_stop_gate
    import fsg_pkg::*;
#(
    parameter int NUM_PF = 3,
    parameter int PF_W   = 2,
    parameter int TAG_W  = 8,
    parameter int CSR_W  = 64
) (
    input  logic              clk,
    input  logic              mac_rst_n,
    input  logic              soft_rst_n,
    input  logic [NUM_PF-1:0] flr_enter,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PF_W-1:0]   req_pf,
    input  logic              req_np,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              core_valid,
    input  logic              core_ready,
    output logic [PF_W-1:0]   core_pf,
    output logic              core_np,
    output logic [TAG_W-1:0]  core_tag,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [PF_W-1:0]   cpl_pf,
    output logic [TAG_W-1:0]  cpl_tag,
    input  logic              csr_wr,
    input  logic              csr_addr,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata,
    output logic              err_irq
);

    localparam int PAD_W = CSR_W - NUM_PF;

    logic [NUM_PF-1:0] pf_hot;
    logic [NUM_PF-1:0] stop_q;
    logic [NUM_PF-1:0] status_q;
    logic [NUM_PF-1:0] stop_clr;
    logic [NUM_PF-1:0] status_clr;
    logic [NUM_PF-1:0] status_set;
    logic              hit_stop;
    logic              slot_free;
    logic              drop;

    // one-hot decode of the owning function; out-of-range values match nothing
    for (genvar g = 0; g < NUM_PF; g++) begin : g_hot
        assign pf_hot[g] = (req_pf == PF_W'(g));
    end

    assign hit_stop = |(pf_hot & stop_q);

    // request steering
    always_comb begin
        core_valid = req_valid && !hit_stop;
        core_pf    = req_pf;
        core_np    = req_np;
        core_tag   = req_tag;
        if (hit_stop) begin
            req_ready = req_np ? slot_free : 1'b1;
        end else begin
            req_ready = core_ready;
        end
    end

    assign drop       = req_valid && req_ready && hit_stop;
    assign status_set = drop ? pf_hot : '0;

    // register writes: one per bit clears
    always_comb begin
        stop_clr   = '0;
        status_clr = '0;
        if (csr_wr) begin
            if (fsg_sel_e'(csr_addr) == SEL_STOP) begin
                stop_clr = csr_wdata[NUM_PF-1:0];
            end else begin
                status_clr = csr_wdata[NUM_PF-1:0];
            end
        end
    end

    fsg_w1c_bank #(.N(NUM_PF)) u_stop (
        .clk       (clk),
        .mac_rst_n (mac_rst_n),
        .wipe_i    (1'b0),
        .set_i     (flr_enter),
        .clr_i     (stop_clr),
        .q_o       (stop_q)
    );

    fsg_w1c_bank #(.N(NUM_PF)) u_status (
        .clk       (clk),
        .mac_rst_n (mac_rst_n),
        .wipe_i    (!soft_rst_n),
        .set_i     (status_set),
        .clr_i     (status_clr),
        .q_o       (status_q)
    );

    fsg_err_slot #(.TAG_W(TAG_W), .PF_W(PF_W)) u_slot (
        .clk        (clk),
        .mac_rst_n  (mac_rst_n),
        .soft_rst_n (soft_rst_n),
        .load_i     (drop && req_np),
        .tag_i      (req_tag),
        .pf_i       (req_pf),
        .free_o     (slot_free),
        .valid_o    (cpl_valid),
        .ready_i    (cpl_ready),
        .tag_o      (cpl_tag),
        .pf_o       (cpl_pf)
    );

    // read mux
    always_comb begin
        if (fsg_sel_e'(csr_addr) == SEL_STOP) begin
            csr_rdata = {{PAD_W{1'b0}}, stop_q};
        end else begin
            csr_rdata = {{PAD_W{1'b0}}, status_q};
        end
    end

    assign err_irq = |status_q;

endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
    parameter int NUM_PF = 3,
    parameter int PF_W   = 2,
    parameter int TAG_W  = 8
) (
    input logic              clk,
    input logic              mac_rst_n,
    input logic              soft_rst_n,
    input logic [NUM_PF-1:0] flr_enter,
    input logic              req_valid,
    input logic              req_ready,
    input logic [PF_W-1:0]   req_pf,
    input logic              req_np,
    input logic [TAG_W-1:0]  req_tag,
    input logic              core_valid,
    input logic              cpl_valid,
    input logic              cpl_ready,
    input logic [TAG_W-1:0]  cpl_tag,
    input logic              csr_wr,
    input logic              csr_addr,
    input logic [NUM_PF-1:0] stop_q,
    input logic [NUM_PF-1:0] status_q,
    input logic              err_irq
);

    p_flr_sets_r2: assert property (@(posedge clk) disable iff (!mac_rst_n)
        (|flr_enter) |=> ((stop_q & $past(flr_enter)) == $past(flr_enter)));

    for (genvar i = 0; i < NUM_PF; i++) begin : g_pf
        p_stop_blocks_r3: assert property (@(posedge clk) disable iff (!mac_rst_n)
            (req_valid && req_pf == PF_W'(i) && stop_q[i]) |-> !core_valid);

        p_drop_status_r6: assert property (@(posedge clk) disable iff (!mac_rst_n)
            (soft_rst_n && req_valid && req_ready && !core_valid && req_pf == PF_W'(i))
            |=> (status_q[i] && err_irq));
    end

    p_np_cpl_r5: assert property (@(posedge clk) disable iff (!mac_rst_n)
        (soft_rst_n && req_valid && req_ready && !core_valid && req_np)
        |=> (cpl_valid && cpl_tag == $past(req_tag)));

    p_cpl_hold_r5: assert property (@(posedge clk) disable iff (!mac_rst_n)
        (soft_rst_n && cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_tag)));

    p_irq_fall_r8: assert property (@(posedge clk) disable iff (!mac_rst_n)
        $fell(err_irq) |-> $past((csr_wr && csr_addr) || !soft_rst_n));

    p_soft_keeps_r9: assert property (@(posedge clk) disable iff (!mac_rst_n)
        (!soft_rst_n && !csr_wr) |=> ((stop_q & $past(stop_q)) == $past(stop_q)));

    p_high_pf_passes_r11: assert property (@(posedge clk) disable iff (!mac_rst_n)
        (req_valid && req_pf >= PF_W'(NUM_PF)) |-> core_valid);

endmodule

bind fn_stop_gate fsg_checker #(
    .NUM_PF (NUM_PF),
    .PF_W   (PF_W),
    .TAG_W  (TAG_W)
) u_fsg_checker (
    .clk        (clk),
    .mac_rst_n  (mac_rst_n),
    .soft_rst_n (soft_rst_n),
    .flr_enter  (flr_enter),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_pf     (req_pf),
    .req_np     (req_np),
    .req_tag    (req_tag),
    .core_valid (core_valid),
    .cpl_valid  (cpl_valid),
    .cpl_ready  (cpl_ready),
    .cpl_tag    (cpl_tag),
    .csr_wr     (csr_wr),
    .csr_addr   (csr_addr),
    .stop_q     (stop_q),
    .status_q   (status_q),
    .err_irq    (err_irq)
);

// File: tb/fn_stop_gate_bench.sv
`timescale 1ns/1ps
module fn_stop_gate_bench;

    localparam int NUM_PF = 3;
    localparam int PF_W   = 2;
    localparam int TAG_W  = 8;
    localparam int CSR_W  = 64;
    localparam int NVEC   = 8;

    logic              clk = 1'b0;
    logic              mac_rst_n;
    logic              soft_rst_n;
    logic [NUM_PF-1:0] flr_enter;
    logic              req_valid;
    logic              req_ready;
    logic [PF_W-1:0]   req_pf;
    logic              req_np;
    logic [TAG_W-1:0]  req_tag;
    logic              core_valid;
    logic              core_ready;
    logic [PF_W-1:0]   core_pf;
    logic              core_np;
    logic [TAG_W-1:0]  core_tag;
    logic              cpl_valid;
    logic              cpl_ready;
    logic [PF_W-1:0]   cpl_pf;
    logic [TAG_W-1:0]  cpl_tag;
    logic              csr_wr;
    logic              csr_addr;
    logic [CSR_W-1:0]  csr_wdata;
    logic [CSR_W-1:0]  csr_rdata;
    logic              err_irq;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    fn_stop_gate u_fn_stop_gate (.*);

    // {pf[1:0], np, tag[7:0], core_ready, exp core_valid, exp req_ready, exp cpl}
    // pf1 is stopped while the table runs
    localparam logic [14:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 8'h10, 1'b1, 1'b1, 1'b1, 1'b0},
        {2'd0, 1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd1, 1'b0, 8'h12, 1'b0, 1'b0, 1'b1, 1'b0},
        {2'd1, 1'b1, 8'h13, 1'b0, 1'b0, 1'b1, 1'b1},
        {2'd2, 1'b1, 8'h14, 1'b1, 1'b1, 1'b1, 1'b0},
        {2'd3, 1'b1, 8'h15, 1'b1, 1'b1, 1'b1, 1'b0},
        {2'd1, 1'b1, 8'h16, 1'b1, 1'b0, 1'b1, 1'b1},
        {2'd2, 1'b0, 8'h17, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic wr_csr(input logic a, input logic [63:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic rd_csr(input logic a, output logic [63:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic flr_pulse(input logic [NUM_PF-1:0] m);
        @(negedge clk);
        flr_enter = m;
        @(negedge clk);
        flr_enter = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        mac_rst_n = 1'b0; soft_rst_n = 1'b1; flr_enter = '0;
        req_valid = 1'b0; req_pf = '0; req_np = 1'b0; req_tag = '0;
        core_ready = 1'b0; cpl_ready = 1'b1;
        csr_wr = 1'b0; csr_addr = 1'b0; csr_wdata = '0;
        repeat (3) @(negedge clk);
        mac_rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_csr(1'b0, rd); chk("R1 stop after reset", rd, 64'h0);
        rd_csr(1'b1, rd); chk("R1 status after reset", rd, 64'h0);
        chk("R1 irq after reset", err_irq, 1'b0);
        chk("R10 cpl after reset", cpl_valid, 1'b0);

        // R2: FLR sets its flag
        flr_pulse(3'b010);
        rd_csr(1'b0, rd); chk("R2 flag set by FLR", rd, 64'h2);

        // vector walk: R3, R4, R5, R11
        for (int i = 0; i < NVEC; i++) begin
            logic [14:0] v;
            string lb;
            v = VEC[i];
            lb = v[2] ? "R4" : "R3";
            if (v[14:13] == 2'd3) lb = "R11";
            @(negedge clk);
            req_pf = v[14:13]; req_np = v[12]; req_tag = v[11:4];
            core_ready = v[3]; req_valid = 1'b1;
            #1;
            chk({lb, " core_valid"}, core_valid, v[2]);
            chk({lb, " req_ready"}, req_ready, v[1]);
            if (v[2]) begin
                chk("R4 tag forwarded", core_tag, v[11:4]);
                chk("R4 pf forwarded", core_pf, v[14:13]);
                chk("R4 type forwarded", core_np, v[12]);
            end
            @(negedge clk);
            req_valid = 1'b0; core_ready = 1'b0;
            #1;
            chk("R5 cpl after drop", cpl_valid, v[0]);
            if (v[0]) begin
                chk("R5 cpl tag", cpl_tag, v[11:4]);
                chk("R5 cpl pf", cpl_pf, v[14:13]);
            end
        end

        // R6: status and interrupt after drops on pf1
        @(negedge clk);
        rd_csr(1'b1, rd); chk("R6 status after drops", rd, 64'h2);
        chk("R6 irq level", err_irq, 1'b1);

        // R8: writing 0 has no effect; writing 1 clears; irq falls
        wr_csr(1'b1, 64'h0);
        rd_csr(1'b1, rd); chk("R8 zero write ignored", rd, 64'h2);
        chk("R8 irq still high", err_irq, 1'b1);
        wr_csr(1'b1, 64'h2);
        rd_csr(1'b1, rd); chk("R8 status cleared", rd, 64'h0);
        chk("R8 irq low", err_irq, 1'b0);

        // R5: backpressure on the completion slot
        cpl_ready = 1'b0;
        @(negedge clk);
        req_pf = 2'd1; req_np = 1'b1; req_tag = 8'h21; req_valid = 1'b1;
        @(negedge clk);
        req_tag = 8'h22;
        #1;
        chk("R5 cpl first", cpl_tag, 8'h21);
        chk("R5 stall when slot full", req_ready, 1'b0);
        @(negedge clk);
        #1;
        chk("R5 cpl held valid", cpl_valid, 1'b1);
        chk("R5 cpl held tag", cpl_tag, 8'h21);
        cpl_ready = 1'b1;
        #1;
        chk("R5 accept while draining", req_ready, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R5 second cpl tag", cpl_tag, 8'h22);
        chk("R5 second cpl valid", cpl_valid, 1'b1);
        @(negedge clk);
        #1;
        chk("R5 cpl drained", cpl_valid, 1'b0);
        wr_csr(1'b1, 64'h7);

        // R7: zero and upper-bit writes have no effect on flags
        wr_csr(1'b0, 64'h0);
        rd_csr(1'b0, rd); chk("R7 zero write ignored", rd, 64'h2);
        wr_csr(1'b0, 64'hFFFF_FFFF_FFFF_FFF8);
        rd_csr(1'b0, rd); chk("R7 upper bits ignored", rd, 64'h2);
        // R7: FLR set beats clear in the same cycle
        @(negedge clk);
        flr_enter = 3'b001; csr_wr = 1'b1; csr_addr = 1'b0; csr_wdata = 64'h1;
        @(negedge clk);
        flr_enter = '0; csr_wr = 1'b0; csr_wdata = '0;
        rd_csr(1'b0, rd); chk("R7 set wins over clear", rd, 64'h3);
        wr_csr(1'b0, 64'h1);
        rd_csr(1'b0, rd); chk("R7 one clears", rd, 64'h2);

        // R8: drop beats status clear in the same cycle
        @(negedge clk);
        req_pf = 2'd1; req_np = 1'b0; req_valid = 1'b1;
        csr_wr = 1'b1; csr_addr = 1'b1; csr_wdata = 64'h2;
        @(negedge clk);
        req_valid = 1'b0; csr_wr = 1'b0; csr_wdata = '0;
        rd_csr(1'b1, rd); chk("R8 drop wins over clear", rd, 64'h2);
        rd_csr(1'b1, rd); chk("R1 upper status bits zero", rd[63:NUM_PF], 64'h0);

        // R9: soft reset spares flags, clears status and pending completion
        cpl_ready = 1'b0;
        @(negedge clk);
        req_pf = 2'd1; req_np = 1'b1; req_tag = 8'h31; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R9 cpl pending before soft reset", cpl_valid, 1'b1);
        @(negedge clk);
        soft_rst_n = 1'b0;
        @(negedge clk);
        soft_rst_n = 1'b1;
        rd_csr(1'b0, rd); chk("R9 flags kept", rd, 64'h2);
        rd_csr(1'b1, rd); chk("R9 status cleared", rd, 64'h0);
        chk("R9 cpl cleared", cpl_valid, 1'b0);
        chk("R9 irq low", err_irq, 1'b0);
        cpl_ready = 1'b1;

        // R10: MAC reset clears flags and status
        flr_pulse(3'b100);
        @(negedge clk);
        req_pf = 2'd2; req_np = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rd_csr(1'b1, rd); chk("R6 status pf2", rd, 64'h4);
        mac_rst_n = 1'b0;
        @(negedge clk);
        mac_rst_n = 1'b1;
        rd_csr(1'b0, rd); chk("R10 flags cleared", rd, 64'h0);
        rd_csr(1'b1, rd); chk("R10 status cleared", rd, 64'h0);
        chk("R10 irq low", err_irq, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule